// File: doc/BRIEF.md
# Dual-Channel Wiper Register Controller

This block holds the digital state of a two-channel tap selector. Each channel has a 9-bit register: an 8-bit wiper position and one output-buffer mode bit. A 24-bit command word arrives with a one-cycle strobe once a serial front end has received and validated it. The block decodes the word, updates the channel registers and drives the wiper and buffer-mode outputs. It also issues fetch, write and clear requests to an external non-volatile storage controller, which holds four 9-bit slots per channel.

The buffer-mode bit can change only by a fetch from storage. Direct writes and step commands touch the wiper alone, and the step commands clamp at both ends of the scale. After reset, and after a software reset command, the block fetches slot 0 of every channel and then rests in a sleep state. In that state it acts on nothing but a wake command. Read commands place a 9-bit value in a readback register, which the serial front end sends out in the following frame.

Top module: `wiper_ctrl`

## Requirements
- R1: Reset (synchronous, active high) clears the registers and puts the block in sleep with `busy_o` high. It then fetches slot 0 into channel 0 and then into channel 1, using fetch requests (`nv_op_o` = 0). `busy_o` falls once both values are loaded.
- R2: While asleep, a command is accepted only if its opcode (bits 23:20) is 0001 (wake). Wake clears `asleep_o`. Any other command leaves the registers unchanged and issues no storage request.
- R3: Opcode 0100 (write) loads data bits 7:0 into the wiper of the addressed channel and leaves that channel's buffer-mode bit unchanged. The channel address is bits 17:16 and the data field is bits 8:0.
- R4: Opcode 0111 (step up) adds exactly one to the addressed wiper and holds it at 255.
- R5: Opcode 1111 (step down) subtracts exactly one from the addressed wiper and holds it at 0.
- R6: Opcode 1011 (fetch) reads the slot given by bits 19:18 of the addressed channel and copies all 9 bits into that channel: bit 8 becomes the buffer mode and bits 7:0 the wiper. Nothing else changes the buffer mode.
- R7: Opcode 0011 (save) issues a write request (`nv_op_o` = 1) carrying the channel's current {mode, wiper}. Opcode 0010 (program) issues a write request carrying data bits 8:0. Opcode 1101 (erase) issues a clear request (`nv_op_o` = 2). Each request carries the channel and slot fields of the command.
- R8: Opcode 1100 places the addressed channel's {mode, wiper} in `rdback_o` on the next cycle. Opcode 1010 places the addressed slot's content in `rdback_o` once storage answers.
- R9: A command whose channel field is 2 or 3 changes no register and issues no request.
- R10: Opcode 1000 puts the block to sleep with its registers kept. Opcode 1001 (software reset) puts the block to sleep, clears `rdback_o` and repeats the slot-0 fetch sequence of R1.
- R11: A command that arrives while `busy_o` is high is dropped. Undefined opcodes (0101, 0110, 1110) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_word_i | input | 24 | Command word: opcode 23:20, slot 19:18, channel 17:16, data 8:0 |
| wiper_o | output | 16 | Wiper positions, channel 0 in bits 7:0 |
| bufmode_o | output | 2 | Buffer-mode bits, one per channel |
| asleep_o | output | 1 | Sleep state |
| busy_o | output | 1 | Storage access outstanding; commands are dropped |
| rdback_o | output | 9 | Readback register for the next serial frame |
| nv_req_o | output | 1 | Storage request strobe |
| nv_op_o | output | 2 | Request kind: 0 fetch, 1 write, 2 clear |
| nv_chan_o | output | 2 | Request channel |
| nv_slot_o | output | 2 | Request slot |
| nv_wdata_o | output | 9 | Write data |
| nv_rvalid_i | input | 1 | Fetch response strobe |
| nv_rdata_i | input | 9 | Fetch response data |

## Verification
The hardest case to produce is a command that lands while a storage fetch is still outstanding. It arrives only when the bench raises the strobe on the cycle right after a fetch command, which the storage model answers three cycles later. The bench holds the strobe high for two cycles: the first cycle carries a fetch and the second a conflicting write. It then checks that the fetched value wins. The sleep path needs the same care, because after reset the block must be woken before any other test can run. Sleep-state rejection is therefore checked first, straight after the boot fetches.

// File: rtl/wctl_pkg.sv
package wctl_pkg;
  localparam int CMD_W = 24;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP     = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_WAKE    = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_PROG    = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_SAVE    = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_WRITE   = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_UP      = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_SLEEP   = 4'b1000;
  localparam logic [OPC_W-1:0] OPC_SRST    = 4'b1001;
  localparam logic [OPC_W-1:0] OPC_PEEK_NV = 4'b1010;
  localparam logic [OPC_W-1:0] OPC_RECALL  = 4'b1011;
  localparam logic [OPC_W-1:0] OPC_PEEK_W  = 4'b1100;
  localparam logic [OPC_W-1:0] OPC_ERASE   = 4'b1101;
  localparam logic [OPC_W-1:0] OPC_DOWN    = 4'b1111;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_WAKE, ACT_SLEEP, ACT_SRST, ACT_WRITE, ACT_UP, ACT_DOWN,
    ACT_RECALL, ACT_PEEK_NV, ACT_PEEK_W, ACT_SAVE, ACT_PROG, ACT_ERASE
  } act_e;

  typedef enum logic [1:0] {
    NV_FETCH = 2'd0,
    NV_WRITE = 2'd1,
    NV_CLEAR = 2'd2
  } nvop_e;

  typedef enum logic [2:0] {
    RF_HOLD, RF_LOAD_ALL, RF_SET_WIPER, RF_STEP_UP, RF_STEP_DN
  } rfop_e;

  typedef enum logic [2:0] {
    ST_BOOT_REQ, ST_BOOT_WAIT, ST_IDLE, ST_FETCH_WAIT, ST_PEEK_WAIT
  } st_e;

  typedef struct packed {
    act_e act;
    logic chan_ok;
  } dec_t;
endpackage

// File: rtl/wctl_decode.sv
module wctl_decode
  import wctl_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CHW   = 2,
  parameter int SLW   = 2,
  parameter int WW    = 8,
  parameter int WORDW = CMD_W
) (
  input  logic [WORDW-1:0] word_i,
  output dec_t             dec_o,
  output logic [CHW-1:0]   chan_o,
  output logic [SLW-1:0]   slot_o,
  output logic [WW:0]      data_o
);
  localparam int OPC_LSB  = WORDW - OPC_W;
  localparam int SLOT_LSB = OPC_LSB - SLW;
  localparam int CHAN_LSB = SLOT_LSB - CHW;
  localparam logic [CHW:0] NCH_V = NCH[CHW:0];

  logic [OPC_W-1:0] opc;

  assign opc    = word_i[OPC_LSB +: OPC_W];
  assign slot_o = word_i[SLOT_LSB +: SLW];
  assign chan_o = word_i[CHAN_LSB +: CHW];
  assign data_o = word_i[WW:0];

  always_comb begin
    dec_o.chan_ok = ({1'b0, chan_o} < NCH_V);
    case (opc)
      OPC_WAKE:    dec_o.act = ACT_WAKE;
      OPC_SLEEP:   dec_o.act = ACT_SLEEP;
      OPC_SRST:    dec_o.act = ACT_SRST;
      OPC_WRITE:   dec_o.act = ACT_WRITE;
      OPC_UP:      dec_o.act = ACT_UP;
      OPC_DOWN:    dec_o.act = ACT_DOWN;
      OPC_RECALL:  dec_o.act = ACT_RECALL;
      OPC_PEEK_NV: dec_o.act = ACT_PEEK_NV;
      OPC_PEEK_W:  dec_o.act = ACT_PEEK_W;
      OPC_SAVE:    dec_o.act = ACT_SAVE;
      OPC_PROG:    dec_o.act = ACT_PROG;
      OPC_ERASE:   dec_o.act = ACT_ERASE;
      default:     dec_o.act = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/wctl_regfile.sv
module wctl_regfile
  import wctl_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CHW = 2,
  parameter int WW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  rfop_e             op_i,
  input  logic [CHW-1:0]    idx_i,
  input  logic [WW:0]       val_i,
  output logic [NCH*WW-1:0] wiper_o,
  output logic [NCH-1:0]    mode_o,
  output logic [WW:0]       sel_o
);
  localparam logic [WW-1:0] WMAX = {WW{1'b1}};
  localparam logic [WW-1:0] WMIN = '0;

  logic [WW:0] flat [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [WW-1:0] w_q;
    logic          m_q;
    logic          hit;

    assign hit = (idx_i == CHW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        w_q <= WMIN;
        m_q <= 1'b0;
      end else if (hit) begin
        case (op_i)
          RF_LOAD_ALL:  {m_q, w_q} <= val_i;
          RF_SET_WIPER: w_q <= val_i[WW-1:0];
          RF_STEP_UP:   if (w_q != WMAX) w_q <= w_q + 1'b1;
          RF_STEP_DN:   if (w_q != WMIN) w_q <= w_q - 1'b1;
          default: ;
        endcase
      end
    end

    assign wiper_o[g*WW +: WW] = w_q;
    assign mode_o[g]           = m_q;
    assign flat[g]             = {m_q, w_q};
  end

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < NCH; i++)
      if (idx_i == CHW'(i)) sel_o = flat[i];
  end
endmodule

// File: rtl/wctl_seq.sv
module wctl_seq
  import wctl_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CHW = 2,
  parameter int SLW = 2,
  parameter int WW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid_i,
  input  dec_t           dec_i,
  input  logic [CHW-1:0] chan_i,
  input  logic [SLW-1:0] slot_i,
  input  logic [WW:0]    data_i,
  input  logic [WW:0]    sel_i,
  input  logic           nv_rvalid_i,
  input  logic [WW:0]    nv_rdata_i,
  output rfop_e          rf_op_o,
  output logic [CHW-1:0] rf_idx_o,
  output logic [WW:0]    rf_val_o,
  output logic           nv_req_o,
  output nvop_e          nv_op_o,
  output logic [CHW-1:0] nv_chan_o,
  output logic [SLW-1:0] nv_slot_o,
  output logic [WW:0]    nv_wdata_o,
  output logic           asleep_o,
  output logic           busy_o,
  output logic [WW:0]    rdback_o
);
  localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);

  st_e            st_q;
  logic [CHW-1:0] tgt_q;
  logic           asleep_q;
  logic           live;

  assign live = cmd_valid_i && (st_q == ST_IDLE) && !asleep_q;

  always_comb begin
    rf_op_o  = RF_HOLD;
    rf_idx_o = chan_i;
    rf_val_o = data_i;
    case (st_q)
      ST_BOOT_WAIT, ST_FETCH_WAIT: begin
        rf_idx_o = tgt_q;
        rf_val_o = nv_rdata_i;
        if (nv_rvalid_i) rf_op_o = RF_LOAD_ALL;
      end
      ST_IDLE: begin
        if (live && dec_i.chan_ok) begin
          case (dec_i.act)
            ACT_WRITE: rf_op_o = RF_SET_WIPER;
            ACT_UP:    rf_op_o = RF_STEP_UP;
            ACT_DOWN:  rf_op_o = RF_STEP_DN;
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_BOOT_REQ;
      tgt_q      <= '0;
      asleep_q   <= 1'b1;
      nv_req_o   <= 1'b0;
      nv_op_o    <= NV_FETCH;
      nv_chan_o  <= '0;
      nv_slot_o  <= '0;
      nv_wdata_o <= '0;
      rdback_o   <= '0;
    end else begin
      nv_req_o <= 1'b0;
      case (st_q)
        ST_BOOT_REQ: begin
          nv_req_o  <= 1'b1;
          nv_op_o   <= NV_FETCH;
          nv_chan_o <= tgt_q;
          nv_slot_o <= '0;
          st_q      <= ST_BOOT_WAIT;
        end
        ST_BOOT_WAIT: begin
          if (nv_rvalid_i) begin
            if (tgt_q == LAST_CH) begin
              st_q <= ST_IDLE;
            end else begin
              tgt_q <= tgt_q + 1'b1;
              st_q  <= ST_BOOT_REQ;
            end
          end
        end
        ST_FETCH_WAIT: if (nv_rvalid_i) st_q <= ST_IDLE;
        ST_PEEK_WAIT: begin
          if (nv_rvalid_i) begin
            rdback_o <= nv_rdata_i;
            st_q     <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (cmd_valid_i && asleep_q) begin
            if (dec_i.act == ACT_WAKE) asleep_q <= 1'b0;
          end else if (cmd_valid_i) begin
            case (dec_i.act)
              ACT_SLEEP: asleep_q <= 1'b1;
              ACT_SRST: begin
                asleep_q <= 1'b1;
                tgt_q    <= '0;
                rdback_o <= '0;
                st_q     <= ST_BOOT_REQ;
              end
              ACT_RECALL, ACT_PEEK_NV: begin
                if (dec_i.chan_ok) begin
                  nv_req_o  <= 1'b1;
                  nv_op_o   <= NV_FETCH;
                  nv_chan_o <= chan_i;
                  nv_slot_o <= slot_i;
                  tgt_q     <= chan_i;
                  st_q      <= (dec_i.act == ACT_RECALL) ? ST_FETCH_WAIT : ST_PEEK_WAIT;
                end
              end
              ACT_PEEK_W: if (dec_i.chan_ok) rdback_o <= sel_i;
              ACT_SAVE, ACT_PROG, ACT_ERASE: begin
                if (dec_i.chan_ok) begin
                  nv_req_o   <= 1'b1;
                  nv_op_o    <= (dec_i.act == ACT_ERASE) ? NV_CLEAR : NV_WRITE;
                  nv_chan_o  <= chan_i;
                  nv_slot_o  <= slot_i;
                  nv_wdata_o <= (dec_i.act == ACT_SAVE) ? sel_i :
                                (dec_i.act == ACT_PROG) ? data_i : '0;
                end
              end
              default: ;
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign asleep_o = asleep_q;
  assign busy_o   = (st_q != ST_IDLE);
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wctl_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int WW    = 8,
  parameter int CHW   = 2,
  parameter int SLW   = 2,
  parameter int WORDW = CMD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid_i,
  input  logic [WORDW-1:0]  cmd_word_i,
  output logic [NCH*WW-1:0] wiper_o,
  output logic [NCH-1:0]    bufmode_o,
  output logic              asleep_o,
  output logic              busy_o,
  output logic [WW:0]       rdback_o,
  output logic              nv_req_o,
  output logic [1:0]        nv_op_o,
  output logic [CHW-1:0]    nv_chan_o,
  output logic [SLW-1:0]    nv_slot_o,
  output logic [WW:0]       nv_wdata_o,
  input  logic              nv_rvalid_i,
  input  logic [WW:0]       nv_rdata_i
);
  dec_t           dec;
  logic [CHW-1:0] chan;
  logic [SLW-1:0] slot;
  logic [WW:0]    data;
  logic [WW:0]    sel;
  rfop_e          rf_op;
  logic [CHW-1:0] rf_idx;
  logic [WW:0]    rf_val;
  nvop_e          nv_op;

  wctl_decode #(.NCH(NCH), .CHW(CHW), .SLW(SLW), .WW(WW), .WORDW(WORDW)) u_dec (
    .word_i (cmd_word_i),
    .dec_o  (dec),
    .chan_o (chan),
    .slot_o (slot),
    .data_o (data)
  );

  wctl_seq #(.NCH(NCH), .CHW(CHW), .SLW(SLW), .WW(WW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid_i (cmd_valid_i),
    .dec_i       (dec),
    .chan_i      (chan),
    .slot_i      (slot),
    .data_i      (data),
    .sel_i       (sel),
    .nv_rvalid_i (nv_rvalid_i),
    .nv_rdata_i  (nv_rdata_i),
    .rf_op_o     (rf_op),
    .rf_idx_o    (rf_idx),
    .rf_val_o    (rf_val),
    .nv_req_o    (nv_req_o),
    .nv_op_o     (nv_op),
    .nv_chan_o   (nv_chan_o),
    .nv_slot_o   (nv_slot_o),
    .nv_wdata_o  (nv_wdata_o),
    .asleep_o    (asleep_o),
    .busy_o      (busy_o),
    .rdback_o    (rdback_o)
  );

  wctl_regfile #(.NCH(NCH), .CHW(CHW), .WW(WW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .op_i    (rf_op),
    .idx_i   (rf_idx),
    .val_i   (rf_val),
    .wiper_o (wiper_o),
    .mode_o  (bufmode_o),
    .sel_o   (sel)
  );

  assign nv_op_o = nv_op;
endmodule

// File: rtl/wctl_chk.sv
module wctl_chk #(
  parameter int NCH   = 2,
  parameter int WW    = 8,
  parameter int CHW   = 2,
  parameter int WORDW = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid_i,
  input logic [WORDW-1:0]  cmd_word_i,
  input logic [NCH*WW-1:0] wiper_o,
  input logic [NCH-1:0]    bufmode_o,
  input logic              asleep_o,
  input logic              busy_o,
  input logic              nv_rvalid_i
);
  localparam int OPC_LSB  = WORDW - 4;
  localparam int CHAN_LSB = OPC_LSB - 2 - CHW;
  localparam logic [CHW:0] NCH_V = NCH[CHW:0];

  logic [3:0]     opc;
  logic [CHW-1:0] ch;
  logic           take;

  assign opc  = cmd_word_i[OPC_LSB +: 4];
  assign ch   = cmd_word_i[CHAN_LSB +: CHW];
  assign take = cmd_valid_i && !busy_o && !asleep_o;

  AST_BOOT_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy_o && asleep_o);  // R1

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i && !busy_o && asleep_o && opc != 4'b0001
    |=> $stable(wiper_o) && $stable(bufmode_o) && asleep_o);  // R2

  AST_WRITE_WIPER: assert property (@(posedge clk) disable iff (rst)
    take && opc == 4'b0100 && ch == '0
    |=> wiper_o[WW-1:0] == $past(cmd_word_i[WW-1:0]) && $stable(bufmode_o));  // R3

  AST_UP_CLAMP: assert property (@(posedge clk) disable iff (rst)
    take && opc == 4'b0111 && ch == '0 && wiper_o[WW-1:0] == {WW{1'b1}}
    |=> wiper_o[WW-1:0] == {WW{1'b1}});  // R4

  AST_UP_ONE: assert property (@(posedge clk) disable iff (rst)
    take && opc == 4'b0111 && ch == '0 && wiper_o[WW-1:0] != {WW{1'b1}}
    |=> wiper_o[WW-1:0] == $past(wiper_o[WW-1:0]) + 1'b1);  // R4

  AST_DOWN_CLAMP: assert property (@(posedge clk) disable iff (rst)
    take && opc == 4'b1111 && ch == '0 && wiper_o[WW-1:0] == '0
    |=> wiper_o[WW-1:0] == '0);  // R5

  AST_MODE_ONLY_FETCH: assert property (@(posedge clk) disable iff (rst)
    !nv_rvalid_i |=> $stable(bufmode_o));  // R6

  AST_BAD_CHAN: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_i && !busy_o && ({1'b0, ch} >= NCH_V)
    |=> $stable(wiper_o) && $stable(bufmode_o));  // R9

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
    busy_o && !nv_rvalid_i |=> $stable(wiper_o));  // R11
endmodule

bind wiper_ctrl wctl_chk #(.NCH(NCH), .WW(WW), .CHW(CHW), .WORDW(WORDW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid_i (cmd_valid_i),
  .cmd_word_i  (cmd_word_i),
  .wiper_o     (wiper_o),
  .bufmode_o   (bufmode_o),
  .asleep_o    (asleep_o),
  .busy_o      (busy_o),
  .nv_rvalid_i (nv_rvalid_i)
);

// File: tb/wiper_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic [15:0] wiper;
  logic [1:0]  bufmode;
  logic        asleep, busy;
  logic [8:0]  rdback;
  logic        nv_req;
  logic [1:0]  nv_op;
  logic [1:0]  nv_chan, nv_slot;
  logic [8:0]  nv_wdata;
  logic        nv_rvalid = 1'b0;
  logic [8:0]  nv_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wiper_ctrl u_wiper_ctrl (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_word_i(cmd_word),
    .wiper_o(wiper), .bufmode_o(bufmode), .asleep_o(asleep), .busy_o(busy),
    .rdback_o(rdback), .nv_req_o(nv_req), .nv_op_o(nv_op), .nv_chan_o(nv_chan),
    .nv_slot_o(nv_slot), .nv_wdata_o(nv_wdata), .nv_rvalid_i(nv_rvalid),
    .nv_rdata_i(nv_rdata)
  );

  // storage model: fetch answers three cycles after the request
  logic [8:0] nvm [2][4];
  logic       pend = 1'b0;
  int         cnt = 0;
  logic       pch = 1'b0;
  logic [1:0] psl = '0;
  int         req_cnt = 0;
  logic [1:0] last_op = '0, last_ch = '0, last_sl = '0;
  logic [8:0] last_wd = '0;

  initial begin
    nvm[0][0] = 9'h120; nvm[0][1] = 9'h0FE; nvm[0][2] = 9'h101; nvm[0][3] = 9'h055;
    nvm[1][0] = 9'h0F0; nvm[1][1] = 9'h1FF; nvm[1][2] = 9'h000; nvm[1][3] = 9'h1AA;
  end

  always @(posedge clk) begin
    nv_rvalid <= 1'b0;
    if (nv_req) begin
      req_cnt <= req_cnt + 1;
      last_op <= nv_op; last_ch <= nv_chan; last_sl <= nv_slot; last_wd <= nv_wdata;
      case (nv_op)
        2'd0: begin pend <= 1'b1; cnt <= 2; pch <= nv_chan[0]; psl <= nv_slot; end
        2'd1: nvm[nv_chan[0]][nv_slot] <= nv_wdata;
        2'd2: nvm[nv_chan[0]][nv_slot] <= 9'h1FF;
        default: ;
      endcase
    end else if (pend) begin
      if (cnt == 1) begin
        nv_rvalid <= 1'b1;
        nv_rdata  <= nvm[pch][psl];
        pend      <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [3:0] op, input logic [1:0] sl,
                                     input logic [1:0] ch, input logic [8:0] d);
    return {op, sl, ch, 7'd0, d};
  endfunction

  task automatic send(input logic [23:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [17:0] state18();
    return {bufmode[1], wiper[15:8], bufmode[0], wiper[7:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // {command, expected {mode1, wiper1, mode0, wiper0}}
  localparam logic [41:0] VEC [15] = '{
    {4'h4, 2'd0, 2'd0, 7'd0, 9'h133, 1'b0, 8'hF0, 1'b1, 8'h33},  // R3 D8 ignored
    {4'h4, 2'd0, 2'd1, 7'd0, 9'h105, 1'b0, 8'h05, 1'b1, 8'h33},  // R3
    {4'h7, 2'd0, 2'd0, 7'd0, 9'h000, 1'b0, 8'h05, 1'b1, 8'h34},  // R4
    {4'hF, 2'd0, 2'd1, 7'd0, 9'h000, 1'b0, 8'h04, 1'b1, 8'h34},  // R5
    {4'hB, 2'd1, 2'd0, 7'd0, 9'h000, 1'b0, 8'h04, 1'b0, 8'hFE},  // R6
    {4'h7, 2'd0, 2'd0, 7'd0, 9'h000, 1'b0, 8'h04, 1'b0, 8'hFF},  // R4
    {4'h7, 2'd0, 2'd0, 7'd0, 9'h000, 1'b0, 8'h04, 1'b0, 8'hFF},  // R4 clamp
    {4'hB, 2'd2, 2'd1, 7'd0, 9'h000, 1'b0, 8'h00, 1'b0, 8'hFF},  // R6
    {4'hF, 2'd0, 2'd1, 7'd0, 9'h000, 1'b0, 8'h00, 1'b0, 8'hFF},  // R5 clamp
    {4'h4, 2'd0, 2'd2, 7'd0, 9'h077, 1'b0, 8'h00, 1'b0, 8'hFF},  // R9
    {4'h7, 2'd0, 2'd3, 7'd0, 9'h000, 1'b0, 8'h00, 1'b0, 8'hFF},  // R9
    {4'hB, 2'd1, 2'd1, 7'd0, 9'h000, 1'b1, 8'hFF, 1'b0, 8'hFF},  // R6 mode set
    {4'hF, 2'd0, 2'd1, 7'd0, 9'h000, 1'b1, 8'hFE, 1'b0, 8'hFF},  // R5
    {4'h5, 2'd0, 2'd0, 7'd0, 9'h012, 1'b1, 8'hFE, 1'b0, 8'hFF},  // R11 undefined
    {4'hB, 2'd3, 2'd0, 7'd0, 9'h000, 1'b1, 8'hFE, 1'b0, 8'h55}   // R6
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int n0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset wipers", {16'd0, wiper}, 32'd0);
    chk("R1 reset asleep/busy", {30'd0, asleep, busy}, 32'd3);
    wait_idle();
    chk("R1 boot loads slot0", {14'd0, state18()}, {14'd0, 1'b0, 8'hF0, 1'b1, 8'h20});
    chk("R1 boot fetch count", req_cnt, 2);
    chk("R1 still asleep", {31'd0, asleep}, 32'd1);

    n0 = req_cnt;
    send(mk(4'h4, 2'd0, 2'd0, 9'h099));
    send(mk(4'hB, 2'd1, 2'd0, 9'h000));
    @(negedge clk);
    chk("R2 sleep rejects write", {14'd0, state18()}, {14'd0, 1'b0, 8'hF0, 1'b1, 8'h20});
    chk("R2 sleep no request", req_cnt, n0);
    chk("R2 sleep busy", {31'd0, busy}, 32'd0);
    send(mk(4'h1, 2'd0, 2'd0, 9'h000));
    chk("R2 wake", {31'd0, asleep}, 32'd0);

    for (int i = 0; i < 15; i++) begin
      send(VEC[i][41:18]);
      wait_idle();
      checks++;
      if (state18() !== VEC[i][17:0]) begin
        fails++;
        $display("FAIL R3..R11 table step %0d actual=%h expected=%h", i, state18(), VEC[i][17:0]);
      end
    end

    // R7 storage requests
    send(mk(4'h3, 2'd2, 2'd0, 9'h000));
    @(negedge clk);
    chk("R7 save request", {21'd0, last_op, last_ch, last_sl, last_wd}, {21'd0, 2'd1, 2'd0, 2'd2, 9'h055});
    send(mk(4'h2, 2'd3, 2'd1, 9'h13C));
    @(negedge clk);
    chk("R7 program request", {21'd0, last_op, last_ch, last_sl, last_wd}, {21'd0, 2'd1, 2'd1, 2'd3, 9'h13C});
    send(mk(4'hD, 2'd1, 2'd0, 9'h000));
    @(negedge clk);
    chk("R7 erase request", {25'd0, last_op, last_ch, last_sl}, {25'd0, 2'd2, 2'd0, 2'd1});
    n0 = req_cnt;
    send(mk(4'h3, 2'd0, 2'd3, 9'h000));
    @(negedge clk);
    chk("R9 bad channel no request", req_cnt, n0);

    // R8 readback
    send(mk(4'hA, 2'd3, 2'd1, 9'h000));
    wait_idle();
    chk("R8 read storage", {23'd0, rdback}, {23'd0, 9'h13C});
    send(mk(4'hC, 2'd0, 2'd1, 9'h000));
    chk("R8 read wiper", {23'd0, rdback}, {23'd0, 9'h1FE});

    // R11 command during outstanding fetch is dropped
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = mk(4'hB, 2'd1, 2'd0, 9'h000);
    @(negedge clk);
    cmd_word  = mk(4'h4, 2'd0, 2'd0, 9'h011);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    chk("R11 busy drop / R6 fetch mode", {14'd0, state18()}, {14'd0, 1'b1, 8'hFE, 1'b1, 8'hFF});

    // R10 sleep and software reset
    send(mk(4'h8, 2'd0, 2'd0, 9'h000));
    chk("R10 sleep entered", {31'd0, asleep}, 32'd1);
    send(mk(4'hF, 2'd0, 2'd0, 9'h000));
    chk("R10 asleep keeps wiper", {24'd0, wiper[7:0]}, 32'hFF);
    send(mk(4'h1, 2'd0, 2'd0, 9'h000));
    send(mk(4'h9, 2'd0, 2'd0, 9'h000));
    chk("R10 srst asleep/busy", {30'd0, asleep, busy}, 32'd3);
    wait_idle();
    chk("R10 srst reload", {14'd0, state18()}, {14'd0, 1'b0, 8'hF0, 1'b1, 8'h20});
    chk("R10 srst readback clear", {23'd0, rdback}, 32'd0);

    finish_run();
  end
endmodule